// File: doc/BRIEF.md
# Nibble-Serial Quadlet CRC-16 Engine

This block computes the 16-bit check value that protects configuration and map blocks on a serial bus, such as a topology map or a speed map. A caller pulses `start` together with the length of the block in quadlets (32-bit words). It then hands over the quadlets one at a time through a valid/ready handshake. The engine folds each quadlet into the running checksum four bits per step, taking the most significant nibble first. After the last nibble of the last quadlet it loads the result register and raises `done` for one cycle.

The running checksum is cleared at every accepted start. Each nibble step computes a four-bit sum: the top nibble of the checksum XOR the incoming nibble. The new checksum is the old one shifted left by four, XOR the sum placed at bit 12, XOR the sum placed at bit 5, XOR the sum at bit 0, with the value kept to 16 bits. By default one nibble is folded per clock. A quadlet therefore occupies the engine for eight cycles: the cycle in which it is accepted, and seven folding cycles during which `in_ready` is low.

Fetching the block from memory, byte-order conversion and writing the header word back all belong to the caller.

Top module: `qcrc16_engine`

## Requirements
- R1: While reset is asserted and after it is released, `in_ready` and `done` are 0 and `crc_out` is 0x0000 until a block completes.
- R2: A quadlet is accepted on a rising edge where both `in_valid` and `in_ready` are 1. `in_ready` then stays 0 for the next 7 cycles while the quadlet is folded.
- R3: The result equals the nibble fold over all quadlets of the block, starting from 0x0000 and taking nibbles from bits 31:28 down to bits 3:0. Each nibble step computes s = crc[15:12] ^ nibble and then crc = ((crc << 4) ^ (s << 12) ^ (s << 5) ^ s) mod 2^16. For example, the single quadlet 0x00000001 gives 0x1021.
- R4: `done` is a single-cycle pulse. It is high in the cycle after the rising edge that folds the eighth nibble of the last quadlet, which is 7 edges after that quadlet was accepted.
- R5: `quad_count` is a number of quadlets. Exactly that many quadlets are accepted. After the last one, `in_ready` stays 0 until a new start, whatever `in_valid` does.
- R6: A start with `quad_count` = 0 raises `done` in the next cycle with `crc_out` = 0x0000.
- R7: `start` is only taken while the engine is idle, which includes the `done` cycle. A start pulse during a block has no effect on its length or its result.
- R8: `crc_out` changes only in a cycle where `done` is high, and holds its value otherwise.
- R9: `in_data` is ignored in cycles where `in_valid` is 0. Stall cycles with arbitrary data do not change the result.
- R10: Blocks as long as a speed map (0x3F1 = 1009 quadlets) are supported with the default count width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block (taken only when idle) |
| quad_count | input | CNT_W (12) | Block length in quadlets, sampled with start |
| in_valid | input | 1 | `in_data` holds a quadlet |
| in_data | input | DATA_W (32) | Quadlet to fold |
| in_ready | output | 1 | Engine can accept a quadlet this cycle |
| done | output | 1 | One-cycle pulse: result valid |
| crc_out | output | CRC_W (16) | Result register, held between blocks |

## Verification
The hardest case to reach is a start pulse that lands in the middle of a block while a quadlet is still being folded or is being offered. The stimulus reaches it by driving `start` with a different length on the same cycle that it offers the second quadlet of a block. A second hard case is stall cycles with random garbage on `in_data`, which are inserted between handshakes. A behavioural model in the bench follows the engine edge by edge and compares `in_ready`, `done` and `crc_out` every cycle. A single fixed vector with a hand-derived result checks that the model and the nibble order agree.

// File: rtl/qcrc_pkg.sv
package qcrc_pkg;
   localparam int NIB_W = 4;

   typedef enum logic [1:0] {
      QS_IDLE = 2'd0,
      QS_WAIT = 2'd1,
      QS_FOLD = 2'd2
   } qseq_e;
endpackage

// File: rtl/qcrc_nibble_step.sv
module qcrc_nibble_step #(
   parameter int CRC_W   = 16,
   parameter int TAP_HI  = 12,
   parameter int TAP_MID = 5
) (
   input  logic [CRC_W-1:0]         crc_in,
   input  logic [qcrc_pkg::NIB_W-1:0] nib,
   output logic [CRC_W-1:0]         crc_out
);
   import qcrc_pkg::*;

   localparam int TOP_LO = CRC_W - NIB_W;

   logic [NIB_W-1:0] sum;
   logic [CRC_W-1:0] sum_w;

   if (TAP_HI + NIB_W > CRC_W) begin : g_bad_tap
      $error("qcrc_nibble_step: upper tap does not fit the checksum width");
   end

   always_comb begin
      sum     = crc_in[CRC_W-1:TOP_LO] ^ nib;
      sum_w   = CRC_W'(sum);
      crc_out = (crc_in << NIB_W) ^ (sum_w << TAP_HI) ^ (sum_w << TAP_MID) ^ sum_w;
   end
endmodule

// File: rtl/qcrc_seq.sv
module qcrc_seq #(
   parameter int CNT_W = 12,
   parameter int STEPS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] quad_count,
   input  logic             in_valid,
   output logic             in_ready,
   output logic             clear,
   output logic             load,
   output logic             step_en,
   output logic             finish,
   output logic             done
);
   import qcrc_pkg::*;

   localparam int PH_W = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(STEPS - 1);

   qseq_e            state;
   logic [CNT_W-1:0] left;
   logic [PH_W-1:0]  phase;
   logic             last_q;
   logic             fold_end;

   always_comb begin
      in_ready = (state == QS_WAIT);
      load     = in_ready && in_valid;
      clear    = (state == QS_IDLE) && start;
      last_q   = (left == CNT_W'(1));
      fold_end = (state == QS_FOLD) && (phase == PH_W'(1));
      step_en  = load || (state == QS_FOLD);
      finish   = (clear && (quad_count == '0))
               || (load && (STEPS == 1) && last_q)
               || (fold_end && last_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= QS_IDLE;
         left  <= '0;
         phase <= '0;
         done  <= 1'b0;
      end else begin
         done <= finish;
         unique case (state)
            QS_IDLE: begin
               if (start && (quad_count != '0)) begin
                  left  <= quad_count;
                  state <= QS_WAIT;
               end
            end
            QS_WAIT: begin
               if (in_valid) begin
                  if (STEPS == 1) begin
                     left <= left - CNT_W'(1);
                     if (last_q) state <= QS_IDLE;
                  end else begin
                     phase <= PH_LAST;
                     state <= QS_FOLD;
                  end
               end
            end
            QS_FOLD: begin
               phase <= phase - PH_W'(1);
               if (phase == PH_W'(1)) begin
                  left  <= left - CNT_W'(1);
                  state <= last_q ? QS_IDLE : QS_WAIT;
               end
            end
            default: state <= QS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/qcrc_datapath.sv
module qcrc_datapath #(
   parameter int DATA_W      = 32,
   parameter int CRC_W       = 16,
   parameter int NIB_PER_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              load,
   input  logic              step_en,
   input  logic              finish,
   input  logic [DATA_W-1:0] in_data,
   output logic [CRC_W-1:0]  crc_out
);
   import qcrc_pkg::*;

   localparam int ADV = NIB_W * NIB_PER_CYC;

   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] src;
   logic [CRC_W-1:0]  crc_run;
   logic [CRC_W-1:0]  crc_base;
   logic [CRC_W-1:0]  chain [NIB_PER_CYC+1];

   always_comb begin
      src      = load ? in_data : shreg;
      crc_base = clear ? '0 : crc_run;
      chain[0] = crc_base;
   end

   for (genvar k = 0; k < NIB_PER_CYC; k++) begin : g_chain
      qcrc_nibble_step #(.CRC_W(CRC_W)) u_step (
         .crc_in  (chain[k]),
         .nib     (src[DATA_W-1-NIB_W*k -: NIB_W]),
         .crc_out (chain[k+1])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg   <= '0;
         crc_run <= '0;
         crc_out <= '0;
      end else begin
         if (step_en) begin
            shreg   <= src << ADV;
            crc_run <= chain[NIB_PER_CYC];
         end else if (clear) begin
            crc_run <= '0;
         end
         if (finish) begin
            crc_out <= step_en ? chain[NIB_PER_CYC] : crc_base;
         end
      end
   end
endmodule

// File: rtl/qcrc16_engine.sv
module qcrc16_engine #(
   parameter int DATA_W      = 32,
   parameter int CRC_W       = 16,
   parameter int CNT_W       = 12,
   parameter int NIB_PER_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  quad_count,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              done,
   output logic [CRC_W-1:0]  crc_out
);
   import qcrc_pkg::*;

   localparam int NIBS  = DATA_W / NIB_W;
   localparam int STEPS = NIBS / NIB_PER_CYC;

   if (DATA_W % NIB_W != 0) begin : g_bad_data
      $error("qcrc16_engine: DATA_W must be a whole number of nibbles");
   end
   if (NIB_PER_CYC < 1 || NIBS % NIB_PER_CYC != 0) begin : g_bad_rate
      $error("qcrc16_engine: NIB_PER_CYC must divide the nibbles per quadlet");
   end
   if (CRC_W != 16) begin : g_bad_crc
      $error("qcrc16_engine: the fold taps are defined for a 16-bit checksum");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("qcrc16_engine: CNT_W must be positive");
   end

   logic clear, load, step_en, finish;

   qcrc_seq #(.CNT_W(CNT_W), .STEPS(STEPS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .quad_count (quad_count),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .clear      (clear),
      .load       (load),
      .step_en    (step_en),
      .finish     (finish),
      .done       (done)
   );

   qcrc_datapath #(.DATA_W(DATA_W), .CRC_W(CRC_W), .NIB_PER_CYC(NIB_PER_CYC)) u_dp (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .load    (load),
      .step_en (step_en),
      .finish  (finish),
      .in_data (in_data),
      .crc_out (crc_out)
   );
endmodule

// File: rtl/qcrc_checker.sv
module qcrc_checker #(
   parameter int DATA_W      = 32,
   parameter int CRC_W       = 16,
   parameter int CNT_W       = 12,
   parameter int NIB_PER_CYC = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [CNT_W-1:0]  quad_count,
   input logic              in_valid,
   input logic              in_ready,
   input logic              done,
   input logic [CRC_W-1:0]  crc_out
);
   localparam int FOLDS = DATA_W / 4 / NIB_PER_CYC - 1;

   logic [CNT_W-1:0] chk_left;
   logic [7:0]       chk_fold;
   logic             started;
   logic             idle;

   assign idle = (chk_left == '0) && (chk_fold == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_left <= '0;
         chk_fold <= '0;
         started  <= 1'b0;
      end else begin
         started <= 1'b1;
         if (idle && start) begin
            chk_left <= quad_count;
         end else if (in_valid && in_ready) begin
            chk_left <= chk_left - CNT_W'(1);
            chk_fold <= 8'(FOLDS);
         end else if (chk_fold != '0) begin
            chk_fold <= chk_fold - 8'd1;
         end
      end
   end

   a_r2_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_fold != '0) |-> !in_ready);

   a_r5_ready_needs_work: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (chk_left != '0));

   a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> idle);

   a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);

   a_r6_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && start && quad_count == '0) |=> (done && crc_out == '0));

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !done) |-> $stable(crc_out));
endmodule

bind qcrc16_engine qcrc_checker #(
   .DATA_W(DATA_W), .CRC_W(CRC_W), .CNT_W(CNT_W), .NIB_PER_CYC(NIB_PER_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .quad_count (quad_count),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .done       (done),
   .crc_out    (crc_out)
);

// File: tb/qcrc16_engine_test.sv
module qcrc16_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [11:0] quad_count = '0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready;
   logic        done;
   logic [15:0] crc_out;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit mon_on = 1'b0;

   always #4 clk = ~clk;

   qcrc16_engine uut (
      .clk(clk), .rst_n(rst_n), .start(start), .quad_count(quad_count),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .done(done), .crc_out(crc_out)
   );

   function automatic logic [15:0] fold_q(input logic [15:0] c, input logic [31:0] q);
      int acc = int'(c);
      for (int s = 28; s >= 0; s -= 4) begin
         int sm = ((acc >> 12) ^ int'(q >> s)) & 15;
         acc = (acc << 4) ^ (sm << 12) ^ (sm << 5) ^ sm;
      end
      return acc[15:0];
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // behavioural reference, advanced on every rising edge
   int          m_state = 0;   // 0 idle, 1 waiting, 2 folding
   int          m_left = 0;
   int          m_fold = 0;
   logic [15:0] m_crc = '0;
   logic [15:0] m_res = '0;
   bit          m_done = 1'b0;

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_state = 0; m_left = 0; m_fold = 0; m_crc = '0; m_res = '0; m_done = 1'b0;
      end else begin
         m_done = 1'b0;
         case (m_state)
            0: if (start) begin
               if (quad_count == 0) begin m_done = 1'b1; m_res = '0; end
               else begin m_left = int'(quad_count); m_crc = '0; m_state = 1; end
            end
            1: if (in_valid) begin
               m_crc = fold_q(m_crc, in_data);
               m_left--; m_fold = 7; m_state = 2;
            end
            default: begin
               m_fold--;
               if (m_fold == 0) begin
                  if (m_left == 0) begin m_done = 1'b1; m_res = m_crc; m_state = 0; end
                  else m_state = 1;
               end
            end
         endcase
      end
   end

   always @(negedge clk) begin
      if (mon_on && rst_n) begin
         chk(in_ready == (m_state == 1), "R2", "in_ready vs model", in_ready, m_state == 1);
         chk(done == m_done, "R4", "done vs model", done, m_done);
         chk(crc_out == m_res, "R8", "crc_out vs model", crc_out, m_res);
      end
   end

   always @(posedge clk) begin
      if (cycles > 150000) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic send_list(input logic [31:0] q[$], input bit stall, input bit poke,
                            input string req);
      logic [15:0] exp = '0;
      foreach (q[i]) exp = fold_q(exp, q[i]);
      @(negedge clk); start = 1'b1; quad_count = 12'(q.size());
      @(negedge clk); start = 1'b0;
      foreach (q[i]) begin
         if (stall) begin
            repeat ($urandom_range(0, 3)) begin
               in_valid = 1'b0; in_data = $urandom; @(negedge clk);
            end
         end
         in_valid = 1'b1; in_data = q[i];
         if (poke && i == 1) begin start = 1'b1; quad_count = 12'd3; end
         while (!in_ready) begin @(negedge clk); start = 1'b0; end
         @(negedge clk);
         start = 1'b0; in_valid = 1'b0; in_data = $urandom;
      end
      while (!done) @(negedge clk);
      chk(crc_out == exp, req, "block result", crc_out, exp);
   endtask

   task automatic rand_block(input int n, input bit stall, input bit poke, input string req);
      logic [31:0] q[$];
      for (int i = 0; i < n; i++) q.push_back($urandom);
      send_list(q, stall, poke, req);
   endtask

   initial begin
      logic [31:0] one[$];
      logic [15:0] held;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
      chk(done == 1'b0, "R1", "done in reset", done, 0);
      chk(crc_out == 16'h0, "R1", "crc_out in reset", crc_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b0 && done == 1'b0 && crc_out == 16'h0, "R1", "idle after reset",
          {in_ready, done, crc_out}, 0);
      mon_on = 1'b1;

      // R6: zero-length block
      start = 1'b1; quad_count = 12'd0;
      @(negedge clk); start = 1'b0;
      chk(done == 1'b1, "R6", "done after zero count", done, 1);
      chk(crc_out == 16'h0, "R6", "result of zero count", crc_out, 0);
      @(negedge clk);
      chk(done == 1'b0, "R4", "done is one cycle", done, 0);

      // R3: hand-derived vector
      one.push_back(32'h0000_0001);
      send_list(one, 1'b0, 1'b0, "R3");
      chk(crc_out == 16'h1021, "R3", "fixed vector 0x00000001", crc_out, 16'h1021);

      // R3 and R9: random blocks, with and without stalls
      for (int b = 0; b < 12; b++) rand_block($urandom_range(1, 64), 1'b0, 1'b0, "R3");
      for (int b = 0; b < 12; b++) rand_block($urandom_range(1, 64), 1'b1, 1'b0, "R9");

      // R7: start pulse during a running block
      for (int b = 0; b < 4; b++) rand_block($urandom_range(2, 40), 1'b1, 1'b1, "R7");

      // R5 and R8: traffic after completion, no start
      @(negedge clk);
      held = crc_out;
      for (int k = 0; k < 6; k++) begin
         in_valid = 1'b1; in_data = $urandom;
         @(negedge clk);
         chk(in_ready == 1'b0, "R5", "no acceptance after last quadlet", in_ready, 0);
         chk(crc_out == held, "R8", "result held", crc_out, held);
      end
      in_valid = 1'b0;

      // R10: speed-map sized block
      rand_block(1009, 1'b0, 1'b0, "R10");

      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule